// File: doc/BRIEF.md
# DMA error status and interrupt pulser

This block holds the error status of a DMA channel controller and drives one pulsed error interrupt towards the processor. It latches a transfer-completion-code error and, for each event queue, a threshold-exceeded error. For each queue it also keeps a sticky threshold-exceeded flag and a watermark, which is the largest queue occupancy reported so far. Two pending summaries computed elsewhere also feed the interrupt logic: one from the event-miss registers and one from the queue-event-miss register.

Software controls the block through a write-only register port. The clear register has write-one-to-clear bits, one per latched error. The evaluate register has two command bits. One forces an interrupt pulse. The other re-arms the interrupt: it pulses only when some error source is still uncleared. Error sources that become pending on their own raise a pulse only on the transition from nothing pending to something pending. Software must therefore clear the errors it has handled and then issue an evaluate command, so that errors which arrived in the meantime are not missed.

Top module: `dma_err_pulser`

## Requirements
- R1: After reset, every status output, every watermark and the interrupt output are 0.
- R2: A high on tc_err_i sets tc_err_o from the next cycle, and the bit stays set until a write to the clear register (offset 0x31C) with data bit 16 set clears it in the cycle that follows.
- R3: A high on q_thr_i[n] sets both q_err_o[n] and q_thrx_o[n], and both stay set. While q_occ_vld_i[n] is high, watermark n (bits 5n+4:5n of q_occ_i and of q_wm_o) takes the occupancy value if that value is larger than the stored one, and otherwise keeps its value.
- R4: A write to the clear register with data bit n set (n = 0 or 1) clears q_wm_o slice n, q_thrx_o[n] and q_err_o[n] together in the next cycle. It leaves the other queue and tc_err_o unchanged.
- R5: A clear-register write with 0 in bit 16 and in bits 1:0 changes no status and pulses nothing, whatever the reserved bits 31:17 and 15:2 hold. The same holds for an evaluate-register write (offset 0x320) with 0 in bits 1:0, and for a write to any other offset.
- R6: When an error event and its clear bit arrive in the same cycle, the error bit ends up set. For a queue, the threshold-exceeded flag also ends up set.
- R7: A write of 1 to evaluate bit 1 (SET) makes err_irq_o high in the next cycle, whatever the error state.
- R8: A write of 1 to evaluate bit 0 (EVAL) makes err_irq_o high in the next cycle if tc_err_o, any q_err_o bit, emr_pend_i or qemr_pend_i is high in the write cycle. Otherwise it produces no pulse.
- R9: The interrupt pulses when the pending state (the OR of tc_err_o, q_err_o, emr_pend_i and qemr_pend_i) goes from 0 to 1. For an external summary input the pulse comes one cycle after the input rises. For a latched error event it comes two cycles after the event. Events that arrive while something is already pending produce no pulse.
- R10: err_irq_o is never high for two cycles in a row. Triggers in the same cycle merge into one pulse, and a trigger in the cycle right after a pulse is absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register byte offset |
| wr_data_i | input | 32 | Register write data |
| tc_err_i | input | 1 | Transfer-completion-code error event |
| q_thr_i | input | 2 | Per-queue threshold-exceeded event |
| q_occ_vld_i | input | 2 | Per-queue occupancy report valid |
| q_occ_i | input | 10 | Per-queue occupancy, 5 bits per queue |
| emr_pend_i | input | 1 | Event-miss registers have an error pending |
| qemr_pend_i | input | 1 | Queue-event-miss register has an error pending |
| tc_err_o | output | 1 | Latched transfer-completion-code error |
| q_err_o | output | 2 | Latched per-queue threshold errors |
| q_thrx_o | output | 2 | Sticky per-queue threshold-exceeded flags |
| q_wm_o | output | 10 | Per-queue watermarks, 5 bits per queue |
| err_irq_o | output | 1 | Error interrupt, one-cycle pulse |

## Verification
Status bits and watermarks are updated one cycle after an event or a clear write. SET and EVAL pulses, and pulses from the external summaries, appear one cycle after their cause. A pulse caused by a latched error appears two cycles after the event, because it passes the status register first. The bench applies each stimulus for exactly one clock edge and samples 1 ns after that edge. It then checks the interrupt at the edge where the count above says the pulse is due, and again one edge later to confirm the pulse has ended. The sweep over every combination of clear bits re-arms all error sources before each write, so each combination starts from the same known state.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;
  localparam int unsigned TC_CLR_BIT = 16;
  localparam int unsigned SET_BIT    = 1;
  localparam int unsigned EVAL_BIT   = 0;
endpackage

// File: rtl/dma_err_regif.sv
module dma_err_regif
  import dma_err_pkg::*;
#(
  parameter int unsigned NUM_Q  = 2,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 'h31C,
  parameter logic [ADDR_W-1:0] EVAL_ADDR = 'h320
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tc_clr_o,
  output logic [NUM_Q-1:0]  q_clr_o,
  output logic              set_cmd_o,
  output logic              eval_cmd_o
);
  logic hit_clr, hit_eval;
  logic unused_data;

  assign hit_clr  = wr_en_i && (wr_addr_i == CLR_ADDR);
  assign hit_eval = wr_en_i && (wr_addr_i == EVAL_ADDR);

  assign tc_clr_o   = hit_clr && wr_data_i[TC_CLR_BIT];
  assign set_cmd_o  = hit_eval && wr_data_i[SET_BIT];
  assign eval_cmd_o = hit_eval && wr_data_i[EVAL_BIT];

  for (genvar i = 0; i < NUM_Q; i++) begin : g_qclr
    assign q_clr_o[i] = hit_clr && wr_data_i[i];
  end

  // reserved bits are don't-care
  assign unused_data = ^wr_data_i;
endmodule

// File: rtl/dma_err_qstat.sv
module dma_err_qstat #(
  parameter int unsigned WM_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            thr_evt_i,
  input  logic            occ_vld_i,
  input  logic [WM_W-1:0] occ_i,
  input  logic            clr_i,
  output logic [WM_W-1:0] wm_o,
  output logic            thrx_o,
  output logic            err_o
);
  logic [WM_W-1:0] wm_q;
  logic            thrx_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wm_q   <= '0;
      thrx_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      // set wins over clear
      if (thr_evt_i) begin
        thrx_q <= 1'b1;
        err_q  <= 1'b1;
      end else if (clr_i) begin
        thrx_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (clr_i)
        wm_q <= occ_vld_i ? occ_i : '0;
      else if (occ_vld_i && (occ_i > wm_q))
        wm_q <= occ_i;
    end
  end

  assign wm_o   = wm_q;
  assign thrx_o = thrx_q;
  assign err_o  = err_q;
endmodule

// File: rtl/dma_err_irq.sv
module dma_err_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic set_cmd_i,
  input  logic eval_cmd_i,
  output logic irq_o
);
  logic pend_q, irq_q, irq_d;

  assign irq_d = set_cmd_i | (eval_cmd_i & pend_i) | (pend_i & ~pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_i;
      irq_q  <= irq_d & ~irq_q;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_err_pulser.sv
module dma_err_pulser #(
  parameter int unsigned NUM_Q  = 2,
  parameter int unsigned WM_W   = 5,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 'h31C,
  parameter logic [ADDR_W-1:0] EVAL_ADDR = 'h320
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  tc_err_i,
  input  logic [NUM_Q-1:0]      q_thr_i,
  input  logic [NUM_Q-1:0]      q_occ_vld_i,
  input  logic [NUM_Q*WM_W-1:0] q_occ_i,
  input  logic                  emr_pend_i,
  input  logic                  qemr_pend_i,
  output logic                  tc_err_o,
  output logic [NUM_Q-1:0]      q_err_o,
  output logic [NUM_Q-1:0]      q_thrx_o,
  output logic [NUM_Q*WM_W-1:0] q_wm_o,
  output logic                  err_irq_o
);
  logic             tc_clr, set_cmd, eval_cmd, pend;
  logic [NUM_Q-1:0] q_clr;
  logic             tc_err_q;

  dma_err_regif #(
    .NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CLR_ADDR(CLR_ADDR), .EVAL_ADDR(EVAL_ADDR)
  ) regif_i (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .tc_clr_o  (tc_clr),
    .q_clr_o   (q_clr),
    .set_cmd_o (set_cmd),
    .eval_cmd_o(eval_cmd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tc_err_q <= 1'b0;
    else if (tc_err_i) tc_err_q <= 1'b1;
    else if (tc_clr)   tc_err_q <= 1'b0;
  end

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    dma_err_qstat #(.WM_W(WM_W)) qstat_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .thr_evt_i(q_thr_i[i]),
      .occ_vld_i(q_occ_vld_i[i]),
      .occ_i    (q_occ_i[i*WM_W +: WM_W]),
      .clr_i    (q_clr[i]),
      .wm_o     (q_wm_o[i*WM_W +: WM_W]),
      .thrx_o   (q_thrx_o[i]),
      .err_o    (q_err_o[i])
    );
  end

  assign pend = tc_err_q | (|q_err_o) | emr_pend_i | qemr_pend_i;

  dma_err_irq irq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend),
    .set_cmd_i (set_cmd),
    .eval_cmd_i(eval_cmd),
    .irq_o     (err_irq_o)
  );

  assign tc_err_o = tc_err_q;
endmodule

// File: rtl/dma_err_chk.sv
module dma_err_chk #(
  parameter int unsigned NUM_Q  = 2,
  parameter int unsigned WM_W   = 5,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 'h31C,
  parameter logic [ADDR_W-1:0] EVAL_ADDR = 'h320
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     wr_addr_i,
  input logic [DATA_W-1:0]     wr_data_i,
  input logic                  tc_err_i,
  input logic [NUM_Q-1:0]      q_thr_i,
  input logic [NUM_Q-1:0]      q_occ_vld_i,
  input logic [NUM_Q*WM_W-1:0] q_occ_i,
  input logic                  emr_pend_i,
  input logic                  qemr_pend_i,
  input logic                  tc_err_o,
  input logic [NUM_Q-1:0]      q_err_o,
  input logic [NUM_Q-1:0]      q_thrx_o,
  input logic [NUM_Q*WM_W-1:0] q_wm_o,
  input logic                  err_irq_o
);
  logic clr_wr, eval_wr, quiet, pend_p;
  logic unused_occ;
  assign clr_wr  = wr_en_i && (wr_addr_i == CLR_ADDR);
  assign eval_wr = wr_en_i && (wr_addr_i == EVAL_ADDR);
  assign quiet   = !tc_err_i && (q_thr_i == '0) && (q_occ_vld_i == '0);
  assign pend_p  = tc_err_o || (q_err_o != '0) || emr_pend_i || qemr_pend_i;
  assign unused_occ = ^q_occ_i;

  // R2
  tc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_err_i |=> tc_err_o);

  // R5
  zero_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == '0 && quiet) |=>
      ($stable(tc_err_o) && $stable(q_err_o) && $stable(q_thrx_o) && $stable(q_wm_o)));

  // R7
  set_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_wr && wr_data_i[1] && !err_irq_o) |=> err_irq_o);

  // R8
  eval_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_wr && wr_data_i[0] && pend_p && !err_irq_o) |=> err_irq_o);

  // R10
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |=> !err_irq_o);

  for (genvar i = 0; i < NUM_Q; i++) begin : g_qchk
    // R4
    q_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_wr && wr_data_i[i] && !q_thr_i[i] && !q_occ_vld_i[i]) |=>
        (q_wm_o[i*WM_W +: WM_W] == '0 && !q_thrx_o[i] && !q_err_o[i]));
    // R6
    q_set_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_thr_i[i] |=> (q_err_o[i] && q_thrx_o[i]));
    // R3
    wm_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(clr_wr && wr_data_i[i]) |=>
        (q_wm_o[i*WM_W +: WM_W] >= $past(q_wm_o[i*WM_W +: WM_W])));
  end
endmodule

bind dma_err_pulser dma_err_chk #(
  .NUM_Q(NUM_Q), .WM_W(WM_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CLR_ADDR(CLR_ADDR), .EVAL_ADDR(EVAL_ADDR)
) chk_i (.*);

// File: tb/dma_err_pulser_tb_top.sv
`timescale 1ns/1ps
module dma_err_pulser_tb_top;
  localparam logic [11:0] CLR  = 12'h31C;
  localparam logic [11:0] EVAL = 12'h320;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [11:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        tc_err_i = 1'b0;
  logic [1:0]  q_thr_i = '0;
  logic [1:0]  q_occ_vld_i = '0;
  logic [9:0]  q_occ_i = '0;
  logic        emr_pend_i = 1'b0;
  logic        qemr_pend_i = 1'b0;
  logic        tc_err_o;
  logic [1:0]  q_err_o, q_thrx_o;
  logic [9:0]  q_wm_o;
  logic        err_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dma_err_pulser dut_i (.*);

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_stat(string req, logic tc, logic [1:0] qe, logic [1:0] tx,
                          logic [4:0] w0, logic [4:0] w1);
    chk({req, " tc"},   {31'd0, tc_err_o}, {31'd0, tc});
    chk({req, " qerr"}, {30'd0, q_err_o},  {30'd0, qe});
    chk({req, " thrx"}, {30'd0, q_thrx_o}, {30'd0, tx});
    chk({req, " wm0"},  {27'd0, q_wm_o[4:0]}, {27'd0, w0});
    chk({req, " wm1"},  {27'd0, q_wm_o[9:5]}, {27'd0, w1});
  endtask

  task automatic chk_irq(string req, logic exp);
    chk({req, " irq"}, {31'd0, err_irq_o}, {31'd0, exp});
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic raise_all(logic [4:0] o1, logic [4:0] o0);
    tc_err_i = 1'b1; q_thr_i = 2'b11; q_occ_vld_i = 2'b11; q_occ_i = {o1, o0};
    tick();
    tc_err_i = 1'b0; q_thr_i = '0; q_occ_vld_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk_stat("R1 reset", 1'b0, 2'b00, 2'b00, 5'd0, 5'd0);
    chk_irq("R1 reset", 1'b0);
    rst_ni = 1'b1;
    tick();

    // R2/R3: events latch, pulse two edges later
    raise_all(5'd12, 5'd7);
    chk_stat("R2 R3 latch", 1'b1, 2'b11, 2'b11, 5'd7, 5'd12);
    chk_irq("R9 not yet", 1'b0);
    tick(); chk_irq("R9 rising pending", 1'b1);
    tick(); chk_irq("R10 pulse ends", 1'b0);

    // R3: watermark keeps maximum
    q_occ_vld_i = 2'b11; q_occ_i = {5'd20, 5'd5};
    tick();
    q_occ_vld_i = '0;
    chk_stat("R3 wm max", 1'b1, 2'b11, 2'b11, 5'd7, 5'd20);

    // R5: writes with no command bit
    wr(CLR, 32'h0);            chk_stat("R5 clr zero", 1'b1, 2'b11, 2'b11, 5'd7, 5'd20);
    chk_irq("R5 clr zero", 1'b0);
    wr(CLR, 32'hFFFE_FFFC);    chk_stat("R5 clr reserved", 1'b1, 2'b11, 2'b11, 5'd7, 5'd20);
    chk_irq("R5 clr reserved", 1'b0);
    wr(12'h100, 32'h0001_0003); chk_stat("R5 other addr", 1'b1, 2'b11, 2'b11, 5'd7, 5'd20);
    chk_irq("R5 other addr", 1'b0);
    wr(EVAL, 32'h0);           chk_irq("R5 eval zero", 1'b0);
    wr(EVAL, 32'hFFFF_FFFC);   chk_irq("R5 eval reserved", 1'b0);
    chk_stat("R5 eval reserved", 1'b1, 2'b11, 2'b11, 5'd7, 5'd20);

    // R2/R4: sweep every non-zero clear combination
    for (int m = 1; m < 8; m++) begin
      logic [2:0] mb;
      mb = 3'(m);
      wr(CLR, {15'd0, mb[2], 14'd0, mb[1], mb[0]});
      chk_stat($sformatf("R2 R4 clear mask %0d", m), ~mb[2], ~mb[1:0], ~mb[1:0],
               mb[0] ? 5'd0 : 5'd7, mb[1] ? 5'd0 : 5'd20);
      raise_all(5'd20, 5'd7);
      tick(); tick();
    end

    // R6: set beats clear in the same cycle
    wr(CLR, 32'h0001_0003); tick(); tick();
    chk_stat("R6 precondition", 1'b0, 2'b00, 2'b00, 5'd0, 5'd0);
    wr_en_i = 1'b1; wr_addr_i = CLR; wr_data_i = 32'h0001_0003;
    tc_err_i = 1'b1; q_thr_i = 2'b01;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0; tc_err_i = 1'b0; q_thr_i = '0;
    chk_stat("R6 collision", 1'b1, 2'b01, 2'b01, 5'd0, 5'd0);
    tick(); tick();

    // R7/R8/R9 with nothing pending, then external summaries
    wr(CLR, 32'h0001_0003); tick(); tick();
    wr(EVAL, 32'h1); chk_irq("R8 eval idle", 1'b0);
    tick();          chk_irq("R8 eval idle later", 1'b0);
    wr(EVAL, 32'h2); chk_irq("R7 set idle", 1'b1);
    tick();          chk_irq("R10 set ends", 1'b0);
    emr_pend_i = 1'b1;
    tick();          chk_irq("R9 emr rise", 1'b1);
    tick();          chk_irq("R10 emr ends", 1'b0);
    wr(EVAL, 32'h1); chk_irq("R8 eval emr", 1'b1);
    tick();
    wr(EVAL, 32'h2); chk_irq("R7 set pending", 1'b1);
    tick();
    emr_pend_i = 1'b0; qemr_pend_i = 1'b1;
    tick();          chk_irq("R9 handover no pulse", 1'b0);
    wr(EVAL, 32'h1); chk_irq("R8 eval qemr", 1'b1);
    qemr_pend_i = 1'b0;
    tick(); tick();

    // R9: latched event from idle, then while pending
    tc_err_i = 1'b1; tick(); tc_err_i = 1'b0;
    chk_irq("R9 tc edge1", 1'b0);
    tick();          chk_irq("R9 tc edge2", 1'b1);
    tick();
    q_thr_i = 2'b10; tick(); q_thr_i = '0;
    chk_irq("R9 pending edge1", 1'b0);
    tick();          chk_irq("R9 pending edge2", 1'b0);
    wr(EVAL, 32'h1); chk_irq("R8 eval status", 1'b1);
    tick();

    // R10: merged and back-to-back triggers
    wr(CLR, 32'h0001_0003); tick(); tick();
    emr_pend_i = 1'b1;
    wr(EVAL, 32'h3); chk_irq("R10 merged", 1'b1);
    tick();          chk_irq("R10 merged ends", 1'b0);
    emr_pend_i = 1'b0; tick(); tick();
    wr_en_i = 1'b1; wr_addr_i = EVAL; wr_data_i = 32'h2;
    tick();          chk_irq("R10 b2b first", 1'b1);
    tick();          chk_irq("R10 b2b absorbed", 1'b0);
    wr_en_i = 1'b0; wr_data_i = '0;
    tick();          chk_irq("R10 quiet", 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule